// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an inbound PCI DMA address into a system memory address. Four programmable windows each claim an aligned region of the 32-bit bus address space. A window either maps its region straight onto a translated base, or resolves each 8 KB page through a one-level page table held in system memory. Two extra paths serve 64-bit addresses. One is a fixed direct map that can be switched on for one address range. The other is a scatter-gather path through the last window for addresses with bit 43 set.

A translation starts with a single address on the request port. When the result is known, one response returns a hit flag, the translated address and the address mask that the result covers. Page-table lookups go out on a simple read request/response port. The request stays asserted with a stable address until the read data arrives. Only one translation is in flight at a time. Configuration is write-only: the window registers and the control register are written through a select code and a data word. Software can observe their effect only through translations.

Top module: `dma_win_xlat`

## Requirements
- R1: After reset, every window is disabled, both control enables are clear, `req_ready` is high, and neither `rsp_valid` nor `mem_req_valid` is asserted. The last window's base reads as scatter-gather mode with its enable bit clear.
- R2: `cfg_sel[3:2]` picks the register (0 window base, 1 window size mask, 2 translated base, 3 control) and `cfg_sel[1:0]` picks the window. A 32-bit address hits a window when base bit 0 is set and (addr AND NOT ext) equals base bits 31:20 shifted into place, where ext = size mask OR 0xFFFFF. In direct mode (base bit 1 clear), the response is hit=1, address = (translated base AND NOT ext) OR (addr AND ext) and mask = ext, one cycle after the request is accepted.
- R3: A base write keeps only bits 31:20, 1 and 0. A size mask write keeps only bits 31:20. A translated base write keeps only bits 34:10.
- R4: When several windows hit, the window with the lowest index decides the result.
- R5: In scatter-gather mode (base bit 1 set), the entry address is (translated base AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). It is driven on `mem_req_addr` with `mem_req_valid` high from the cycle after acceptance and held stable until `mem_rsp_valid`. The response follows one cycle after the read data: address = (data bits 21:1 placed at bits 33:13) OR addr bits 12:0, mask 0x1FFF.
- R6: A page table entry with bit 0 clear gives a fault response. Every fault response has hit=0, address 0 and mask 0.
- R7: While control bit 5 is set, 32-bit addresses from 0x80000 to 0xFFFFF fault even when a window covers them. 0x7FFFF and addresses outside that range translate normally, and clearing the bit restores the range.
- R8: While control bit 6 is set, addresses from 0x100_0000_0000 up to but not including 0x200_0000_0000 map to addr AND 0x7_FFFF_FFFF with that same mask. With the bit clear, or outside the range, they fault.
- R9: A base write to window 3 always sets bit 1 and keeps bit 43. With bit 43 set, window 3 takes no part in the 32-bit lookup. While bits 43 and 0 are both set, addresses 0x800_0000_0000 to 0xFFF_FFFF_FFFF fetch the entry at (translated base AND 0x7_FFC0_0000) OR ((addr AND 0xFFFF_E000)>>10) and translate as in R5.
- R10: An address that no path claims gives a fault response one cycle after acceptance and issues no memory read.
- R11: While a table read is pending, `req_ready` is low and requests are ignored. Each translation yields exactly one single-cycle response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 4 | Register select: [3:2] register kind, [1:0] window |
| cfg_wdata_i | input | 44 | Register write data |
| req_valid_i | input | 1 | Translation request |
| req_addr_i | input | 44 | Bus address to translate |
| req_ready_o | output | 1 | High when a request can be accepted |
| mem_req_valid_o | output | 1 | Page table read pending |
| mem_req_addr_o | output | 35 | Page table entry address |
| mem_rsp_valid_i | input | 1 | Page table read data valid |
| mem_rsp_data_i | input | 64 | Page table entry |
| rsp_valid_o | output | 1 | Translation result valid for one cycle |
| rsp_hit_o | output | 1 | 1 for a translation, 0 for a fault |
| rsp_addr_o | output | 44 | Translated address |
| rsp_mask_o | output | 44 | Low address bits passed through unchanged |

## Verification
Direct, fixed-map and fault results appear on the response port one cycle after the clock edge that accepts the request. The bench therefore drives the request for one cycle from a falling edge and reads the response at the next falling edge, where it also confirms that no memory read was raised. For table walks, the memory read is due in that same following cycle. The bench checks the entry address there and again two cycles later to confirm it is held, then supplies the entry. It expects the response exactly one cycle after the read data and expects it to be gone one cycle after that.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int AW = 44;
  localparam int TW = 35;
  localparam int DW = 64;

  typedef enum logic [1:0] {
    F_BASE = 2'd0,
    F_MASK = 2'd1,
    F_TBA  = 2'd2,
    F_CTL  = 2'd3
  } field_e;

  typedef enum logic [1:0] {
    K_MISS   = 2'd0,
    K_DIRECT = 2'd1,
    K_FETCH  = 2'd2
  } kind_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } state_e;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [31:0]   msk;
    logic [TW-1:0] tba;
  } win_t;
endpackage

// File: rtl/dwx_regs.sv
module dwx_regs import dwx_pkg::*; #(
  parameter int NWIN = 4,
  parameter int WSEL = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [WSEL+1:0]       sel_i,
  input  logic [AW-1:0]         wdata_i,
  output win_t [NWIN-1:0]       win_o,
  output logic                  hole_en_o,
  output logic                  hi_dir_en_o
);
  localparam logic [AW-1:0] KEEP_STD  = 44'h000_FFF0_0003;
  localparam logic [AW-1:0] KEEP_LAST = 44'h800_FFF0_0001;
  localparam logic [31:0]   KEEP_MSK  = 32'hFFF0_0000;
  localparam logic [TW-1:0] KEEP_TBA  = 35'h7_FFFF_FC00;

  field_e fld;
  assign fld = field_e'(sel_i[WSEL+1:WSEL]);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [AW-1:0] KEEP  = (g == NWIN-1) ? KEEP_LAST : KEEP_STD;
    localparam logic [AW-1:0] FORCE = (g == NWIN-1) ? 44'h2 : 44'h0;
    win_t q, d;
    logic en;

    assign en = we_i && (fld != F_CTL) && (sel_i[WSEL-1:0] == WSEL'(g));

    always_comb begin
      d = q;
      case (fld)
        F_BASE:  d.base = (wdata_i & KEEP) | FORCE;
        F_MASK:  d.msk  = wdata_i[31:0] & KEEP_MSK;
        F_TBA:   d.tba  = wdata_i[TW-1:0] & KEEP_TBA;
        default: d = q;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '{base: FORCE, msk: '0, tba: '0};
      end else if (en) begin
        q <= d;
      end
    end

    assign win_o[g] = q;
  end

  logic [1:0] ctl_q, ctl_d;
  logic       ctl_en;

  assign ctl_en = we_i && (fld == F_CTL);
  assign ctl_d  = wdata_i[6:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign hole_en_o   = ctl_q[0];
  assign hi_dir_en_o = ctl_q[1];

  // R9: the last window always reports scatter-gather mode once out of reset
  p_last_sg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_en |=> win_o[NWIN-1].base[1]);
endmodule

// File: rtl/dwx_match.sv
module dwx_match import dwx_pkg::*; #(
  parameter int NWIN = 4,
  parameter int WSEL = 2
) (
  input  logic [AW-1:0]   addr_i,
  input  win_t [NWIN-1:0] win_i,
  input  logic            hole_en_i,
  input  logic            hi_dir_en_i,
  output kind_e           kind_o,
  output logic [AW-1:0]   dir_addr_o,
  output logic [AW-1:0]   dir_mask_o,
  output logic [TW-1:0]   entry_o
);
  localparam logic [TW-1:0] DAC_TBA_KEEP = 35'h7_FFC0_0000;
  localparam logic [AW-1:0] HI_MASK      = 44'h007_FFFF_FFFF;

  logic [NWIN-1:0]         hit_v;
  logic [NWIN-1:0][AW-1:0] ext_v;
  logic [NWIN-1:0][AW-1:0] dres_v;
  logic [NWIN-1:0][TW-1:0] ent_v;

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    logic [31:0] ext;
    logic        excl;
    assign ext  = win_i[g].msk | 32'h000F_FFFF;
    assign excl = (g == NWIN-1) ? win_i[g].base[AW-1] : 1'b0;
    assign hit_v[g] = win_i[g].base[0] && !excl &&
                      ((addr_i[31:0] & ~ext) == {win_i[g].base[31:20], 20'h0});
    assign ext_v[g]  = AW'(ext);
    assign dres_v[g] = (AW'(win_i[g].tba) & ~AW'(ext)) | (addr_i & AW'(ext));
    assign ent_v[g]  = (win_i[g].tba & ~TW'(win_i[g].msk >> 10)) |
                       TW'((addr_i[31:0] & (win_i[g].msk | 32'h000F_E000)) >> 10);
  end

  logic [WSEL-1:0] pick;
  logic            any;
  logic            lo32;
  logic            in_hole;
  win_t            last;

  assign lo32    = (addr_i[AW-1:32] == '0);
  assign in_hole = hole_en_i && (addr_i[31:20] == '0) && addr_i[19];
  assign last    = win_i[NWIN-1];

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (hit_v[i]) begin
        pick = WSEL'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    kind_o     = K_MISS;
    dir_addr_o = '0;
    dir_mask_o = '0;
    entry_o    = '0;
    if (lo32) begin
      if (!in_hole && any) begin
        if (win_i[pick].base[1]) begin
          kind_o  = K_FETCH;
          entry_o = ent_v[pick];
        end else begin
          kind_o     = K_DIRECT;
          dir_addr_o = dres_v[pick];
          dir_mask_o = ext_v[pick];
        end
      end
    end else if (addr_i[AW-1:40] == 4'h1 && hi_dir_en_i) begin
      kind_o     = K_DIRECT;
      dir_addr_o = addr_i & HI_MASK;
      dir_mask_o = HI_MASK;
    end else if (addr_i[AW-1] && last.base[AW-1] && last.base[0]) begin
      kind_o  = K_FETCH;
      entry_o = (last.tba & DAC_TBA_KEEP) | TW'({addr_i[31:13], 3'b000});
    end
  end
endmodule

// File: rtl/dma_win_xlat.sv
module dma_win_xlat import dwx_pkg::*; #(
  parameter  int NWIN = 4,
  localparam int WSEL = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [WSEL+1:0] cfg_sel_i,
  input  logic [AW-1:0]   cfg_wdata_i,
  input  logic            req_valid_i,
  input  logic [AW-1:0]   req_addr_i,
  output logic            req_ready_o,
  output logic            mem_req_valid_o,
  output logic [TW-1:0]   mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [DW-1:0]   mem_rsp_data_i,
  output logic            rsp_valid_o,
  output logic            rsp_hit_o,
  output logic [AW-1:0]   rsp_addr_o,
  output logic [AW-1:0]   rsp_mask_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  win_t [NWIN-1:0] win;
  logic            hole_en, hi_dir_en;
  kind_e           kind;
  logic [AW-1:0]   dir_addr, dir_mask;
  logic [TW-1:0]   entry;

  dwx_regs #(.NWIN(NWIN), .WSEL(WSEL)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .win_o      (win),
    .hole_en_o  (hole_en),
    .hi_dir_en_o(hi_dir_en)
  );

  dwx_match #(.NWIN(NWIN), .WSEL(WSEL)) i_match (
    .addr_i     (req_addr_i),
    .win_i      (win),
    .hole_en_i  (hole_en),
    .hi_dir_en_i(hi_dir_en),
    .kind_o     (kind),
    .dir_addr_o (dir_addr),
    .dir_mask_o (dir_mask),
    .entry_o    (entry)
  );

  state_e        state_q, state_d;
  logic [TW-1:0] mem_addr_q, mem_addr_d;
  logic [12:0]   off_q, off_d;
  logic          mem_en;
  logic          rsp_set;
  logic          hit_d, hit_q;
  logic [AW-1:0] addr_d, addr_q, mask_d, mask_q;
  logic          rsp_valid_q;
  logic          unused_rsp_bits;

  assign unused_rsp_bits = ^mem_rsp_data_i[DW-1:22];

  always_comb begin
    state_d    = state_q;
    mem_addr_d = entry;
    off_d      = req_addr_i[12:0];
    mem_en     = 1'b0;
    rsp_set    = 1'b0;
    hit_d      = 1'b0;
    addr_d     = '0;
    mask_d     = '0;
    case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          case (kind)
            K_DIRECT: begin
              rsp_set = 1'b1;
              hit_d   = 1'b1;
              addr_d  = dir_addr;
              mask_d  = dir_mask;
            end
            K_FETCH: begin
              state_d = S_WAIT;
              mem_en  = 1'b1;
            end
            default: rsp_set = 1'b1;
          endcase
        end
      end
      default: begin
        if (mem_rsp_valid_i) begin
          state_d = S_IDLE;
          rsp_set = 1'b1;
          if (mem_rsp_data_i[0]) begin
            hit_d  = 1'b1;
            addr_d = AW'({mem_rsp_data_i[21:1], off_q});
            mask_d = AW'(13'h1FFF);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      rsp_valid_q <= 1'b0;
      mem_addr_q  <= '0;
      off_q       <= '0;
      hit_q       <= 1'b0;
      addr_q      <= '0;
      mask_q      <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_set;
      if (mem_en) begin
        mem_addr_q <= mem_addr_d;
        off_q      <= off_d;
      end
      if (rsp_set) begin
        hit_q  <= hit_d;
        addr_q <= addr_d;
        mask_q <= mask_d;
      end
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_WAIT);
  assign mem_req_addr_o  = mem_addr_q;
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_hit_o       = hit_q;
  assign rsp_addr_o      = addr_q;
  assign rsp_mask_o      = mask_q;

  // R5: a pending table read keeps its address until data returns
  p_fetch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_req_valid_o && !mem_rsp_valid_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R5: a page walk that hits covers exactly one 8 KB page
  p_page_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_req_valid_o && mem_rsp_valid_i && mem_rsp_data_i[0]
      |=> rsp_valid_o && rsp_hit_o && rsp_mask_o == AW'(13'h1FFF));

  // R6: faults carry no address and no mask
  p_fault_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o && !rsp_hit_o |-> rsp_addr_o == '0 && rsp_mask_o == '0);

  // R11: no response while a table read is still outstanding
  p_one_inflight_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_req_valid_o |-> !rsp_valid_o);

  // R11: responses are single-cycle pulses unless a new request was accepted
  p_rsp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o && !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
endmodule

// File: tb/test_dma_win_xlat.sv
module test_dma_win_xlat;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [43:0] cfg_wdata;
  logic        req_valid;
  logic [43:0] req_addr;
  logic        req_ready;
  logic        mem_req_valid;
  logic [34:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [43:0] rsp_addr;
  logic [43:0] rsp_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [1:0] SB = 2'd0, SM = 2'd1, ST = 2'd2, SC = 2'd3;

  dma_win_xlat i_dma_win_xlat (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cfg_we_i       (cfg_we),
    .cfg_sel_i      (cfg_sel),
    .cfg_wdata_i    (cfg_wdata),
    .req_valid_i    (req_valid),
    .req_addr_i     (req_addr),
    .req_ready_o    (req_ready),
    .mem_req_valid_o(mem_req_valid),
    .mem_req_addr_o (mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i (mem_rsp_data),
    .rsp_valid_o    (rsp_valid),
    .rsp_hit_o      (rsp_hit),
    .rsp_addr_o     (rsp_addr),
    .rsp_mask_o     (rsp_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired act=hung exp=done");
    summary();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] fld, input logic [1:0] w, input logic [43:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {fld, w}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // one translation; results sampled at falling edges after the accepting edge
  task automatic xl(input string tag, input logic [43:0] a, input bit fetch,
                    input logic [34:0] ent, input logic [63:0] pte,
                    input bit ehit, input logic [43:0] ea, input logic [43:0] em);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (fetch) begin
      chk({tag, " memreq"}, mem_req_valid, 1);
      chk({tag, " entry"}, mem_req_addr, ent);
      chk({tag, " early rsp"}, rsp_valid, 0);
      repeat (2) @(negedge clk);
      chk({tag, " held"}, {mem_req_valid, mem_req_addr}, {1'b1, ent});
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    end else begin
      chk({tag, " no memreq"}, mem_req_valid, 0);
    end
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " hit"}, rsp_hit, ehit);
    chk({tag, " addr"}, rsp_addr, ea);
    chk({tag, " mask"}, rsp_mask, em);
    @(negedge clk);
    chk({tag, " pulse"}, rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp idle", rsp_valid, 0);
    chk("R1 mem idle", mem_req_valid, 0);
    xl("R1 last window off", 44'h7000_0000, 0, '0, '0, 0, '0, '0);
    xl("R10 unclaimed low", 44'h1234, 0, '0, '0, 0, '0, '0);
  endtask

  task automatic t_direct();
    wr(SB, 0, 44'h4000_0001);
    wr(SM, 0, 44'h0FF0_0000);
    wr(ST, 0, 44'h1_2000_0000);
    xl("R2 direct mid", 44'h4123_4567, 0, '0, '0, 1, 44'h1_2123_4567, 44'h0FFF_FFFF);
    xl("R2 direct top", 44'h4FFF_FFFF, 0, '0, '0, 1, 44'h1_2FFF_FFFF, 44'h0FFF_FFFF);
    xl("R10 above window", 44'h5000_0000, 0, '0, '0, 0, '0, '0);
  endtask

  task automatic t_masks();
    wr(SB, 1, 44'h6000_0001 | 44'h000F_FFFC);
    wr(SM, 1, 44'h000F_FFFF);
    wr(ST, 1, 44'h13_0000_03FF);
    xl("R3 kept bits", 44'h6001_2345, 0, '0, '0, 1, 44'h3_0001_2345, 44'h000F_FFFF);
    xl("R3 size junk dropped", 44'h6010_0000, 0, '0, '0, 0, '0, '0);
  endtask

  task automatic t_prio();
    wr(SB, 2, 44'h4000_0001);
    wr(SM, 2, 44'h0);
    wr(ST, 2, 44'h7_0000_0000);
    xl("R4 lowest wins", 44'h4000_0010, 0, '0, '0, 1, 44'h1_2000_0010, 44'h0FFF_FFFF);
    wr(SB, 0, 44'h4000_0000);
    xl("R4 next window", 44'h4000_0010, 0, '0, '0, 1, 44'h7_0000_0010, 44'h000F_FFFF);
    xl("R10 outside small", 44'h4010_0000, 0, '0, '0, 0, '0, '0);
  endtask

  task automatic t_sg();
    wr(SB, 1, 44'h8000_0003);
    wr(SM, 1, 44'h0010_0000);
    wr(ST, 1, 44'h2_0000_0400);
    xl("R5 walk", 44'h8013_5678, 1, 35'h2_0000_04D0, 64'hFFFF_0000_FFC2_468B,
       1, 44'h2468_B678, 44'h1FFF);
    xl("R5 walk top", 44'h801F_FFFF, 1, 35'h2_0000_07F8, 64'h3,
       1, 44'h3FFF, 44'h1FFF);
    xl("R6 bad entry", 44'h8013_5678, 1, 35'h2_0000_04D0, 64'hFFFF_FFFF_FFFF_FFFE,
       0, '0, '0);
  endtask

  task automatic t_hole();
    wr(SB, 0, 44'h1);
    wr(SM, 0, 44'h0);
    wr(ST, 0, 44'h5_0000_0000);
    xl("R7 hole off", 44'h8_0000, 0, '0, '0, 1, 44'h5_0008_0000, 44'h000F_FFFF);
    wr(SC, 0, 44'h20);
    xl("R7 hole low", 44'h8_0000, 0, '0, '0, 0, '0, '0);
    xl("R7 hole high", 44'hF_FFFF, 0, '0, '0, 0, '0, '0);
    xl("R7 below hole", 44'h7_FFFF, 0, '0, '0, 1, 44'h5_0007_FFFF, 44'h000F_FFFF);
  endtask

  task automatic t_upper();
    xl("R8 map off", 44'h150_1234_5678, 0, '0, '0, 0, '0, '0);
    wr(SC, 0, 44'h40);
    xl("R8 map mid", 44'h150_1234_5678, 0, '0, '0, 1, 44'h1234_5678, 44'h7_FFFF_FFFF);
    xl("R8 map start", 44'h100_0000_0000, 0, '0, '0, 1, 44'h0, 44'h7_FFFF_FFFF);
    xl("R8 map end", 44'h1FF_FFFF_FFFF, 0, '0, '0, 1, 44'h7_FFFF_FFFF, 44'h7_FFFF_FFFF);
    xl("R8 past range", 44'h200_0000_0000, 0, '0, '0, 0, '0, '0);
    xl("R8 below range", 44'hFF_FFFF_FFFF, 0, '0, '0, 0, '0, '0);
    xl("R7 hole cleared", 44'h9_0000, 0, '0, '0, 1, 44'h5_0009_0000, 44'h000F_FFFF);
  endtask

  task automatic t_last();
    wr(SB, 3, 44'h7000_0001);
    wr(SM, 3, 44'h0);
    wr(ST, 3, 44'h1_0000_0000);
    xl("R9 forced walk", 44'h7000_2ABC, 1, 35'h1_0000_0008, 64'h3, 1, 44'h2ABC, 44'h1FFF);
    wr(SB, 3, 44'h800_7000_0001);
    xl("R9 excluded low", 44'h7000_2ABC, 0, '0, '0, 0, '0, '0);
    xl("R9 high walk", 44'h800_1234_5678, 1, 35'h1_0004_8D10, 64'h7, 1, 44'h7678, 44'h1FFF);
    wr(SB, 3, 44'h800_7000_0000);
    xl("R9 high disabled", 44'h800_1234_5678, 0, '0, '0, 0, '0, '0);
    xl("R10 unclaimed high", 44'h700_0000_0000, 0, '0, '0, 0, '0, '0);
  endtask

  task automatic t_busy();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 44'h8013_5678;
    @(negedge clk);
    req_addr = 44'h9_0000;
    chk("R11 busy ready low", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 still one read", {mem_req_valid, mem_req_addr}, {1'b1, 35'h2_0000_04D0});
    chk("R11 no extra rsp", rsp_valid, 0);
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'h3;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    chk("R11 walk result", {rsp_valid, rsp_hit, rsp_addr}, {2'b11, 44'h3678});
    @(negedge clk);
    chk("R11 ignored request", {rsp_valid, mem_req_valid, req_ready}, 3'b001);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_masks();
    t_prio();
    t_sg();
    t_hole();
    t_upper();
    t_last();
    t_busy();
    summary();
  end
endmodule